// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block runs next to an asynchronous UART receiver and measures the bit period of an incoming calibration character, the byte 0x55. Software arms it with an enable write. The block then follows the receive line through a two-flop synchronizer. It counts prescaled clock ticks between the first and the fifth rising edge of the character, a span of exactly eight bit periods. The counter tick runs eight times slower than the normal baud base clock, so the stored total is the average per-bit divisor.

When the measurement completes, the block does four things in one cycle: it stores the total in the divisor register, clears its enable, raises a receive-complete flag and releases the receiver-hold output. A read strobe on the receive data register clears the flag; the data from that read has no meaning. If wake-on-break is requested along with the arm, the block first lets a break (a low period followed by a return high) pass and then measures the following byte. The counter stops at its maximum value instead of wrapping and raises a sticky overflow indication. Writing the enable to 0 during a measurement aborts it.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, the divisor is 0 and the flag, enable, receiver-hold and overflow outputs are all 0.
- R2: The count is loaded with 1 on the first rising edge after the start bit's falling edge. It rises by 1 on every tick until the fifth rising edge. With bit period P system clocks and tick period T, the stored divisor is 1 + floor((8P-1)/T), which is 8P/T when 8P is a multiple of T.
- R3: The tick period T is 2^(BASE_LOG2+4) clocks with both selects 0, 2^(BASE_LOG2+2) clocks with exactly one of fast_i or wide_i set, and 2^BASE_LOG2 clocks with both set. With the default BASE_LOG2=5 these are 512, 128 and 32. The full CNT_W-bit counter is used whatever wide_i says.
- R4: In the cycle that the fifth rising edge is detected, the divisor is written. On the next cycle en_o reads 0 and done_flag_o reads 1.
- R5: rx_hold_o is 1 from the cycle after an enable write of 1 until the measurement completes or is aborted, and 0 otherwise.
- R6: A pulse on rd_i clears done_flag_o. If completion happens in the same cycle, completion wins.
- R7: The counter stops at 2^CNT_W-1. A tick that arrives at that value sets ovf_o. ovf_o stays set until the next enable write of 1.
- R8: An enable write of 0 during a measurement returns the block to idle. The divisor and done_flag_o keep their values, and later activity on the line does not change them.
- R9: If wake_i is 1 when the block is armed, the first falling edge and the rising edge after it (the break) are skipped. The measurement applies to the character that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous receive line, idle high |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit (1 arms, 0 aborts) |
| wake_i | input | 1 | Skip a break before measuring |
| fast_i | input | 1 | High-speed rate select |
| wide_i | input | 1 | 16-bit divisor mode select |
| rd_i | input | 1 | Receive data read strobe, clears the flag |
| divisor_o | output | CNT_W | Measured baud divisor |
| done_flag_o | output | 1 | Receive-complete flag |
| en_o | output | 1 | Enable bit readback |
| rx_hold_o | output | 1 | Holds the normal receiver in idle |
| ovf_o | output | 1 | Sticky counter overflow |

## Verification
The main sweep sends 0x55 at several bit periods under all four select combinations. Some periods give 8P as a multiple of T and some do not, so a wrong load value, a wrong tick rate or an off-by-one tick boundary each shows as a different divisor. A long-period character at the fastest tick drives the counter to saturation, which separates stopping at the maximum from wrapping. A break followed by a character with wake enabled shows whether the break edges were skipped, because counting from the break's rising edge would give a different value. An abort halfway through a character, followed by the rest of that character, shows whether the divisor and flag stay untouched.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BRK_WAIT,
    ST_BRK_LOW,
    ST_START,
    ST_EDGE1,
    ST_COUNT
  } ab_state_t;

  // rising edges of the calibration byte that bound the measured span
  localparam int CAL_EDGES = 5;

  // log2 of the tick period: each select that is set divides the period by 4
  function automatic int tick_shift(int base, logic fast, logic wide);
    int n;
    n = 0;
    if (fast) n = n + 1;
    if (wide) n = n + 1;
    return base + 2 * (2 - n);
  endfunction

endpackage

// File: rtl/ab_rx_edge.sv
module ab_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1, s2, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
    end else begin
      s1   <= rx_i;
      s2   <= s1;
      prev <= s2;
    end
  end

  assign rise_o = s2 & ~prev;
  assign fall_o = ~s2 & prev;
endmodule

// File: rtl/ab_prescale.sv
module ab_prescale #(
  parameter int BASE_LOG2 = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic fast_i,
  input  logic wide_i,
  output logic tick_o
);
  import autobaud_pkg::*;

  localparam int PRE_W = BASE_LOG2 + 4;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim = PRE_W'((32'd1 << tick_shift(BASE_LOG2, fast_i, wide_i)) - 32'd1);
  end

  assign tick_o = run_i && !clr_i && (pre == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (clr_i) begin
      pre <= '0;
    end else if (run_i) begin
      if (tick_o) pre <= '0;
      else        pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/ab_satcnt.sv
module ab_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign sat_hit_o = inc_i && !load_i && (cnt_o == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= CNT_W'(1);
    end else if (inc_i && (cnt_o != CNT_MAX)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/ab_ctrl.sv
module ab_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic wake_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic rd_i,
  output logic en_o,
  output logic load_o,
  output logic run_o,
  output logic done_o,
  output logic flag_o
);
  import autobaud_pkg::*;

  ab_state_t  state;
  logic [2:0] edges;
  logic       arm_evt, abort_evt;

  assign arm_evt   = en_wr_i & en_wdata_i;
  assign abort_evt = en_wr_i & ~en_wdata_i;
  assign load_o    = (state == ST_EDGE1) && rise_i && !en_wr_i;
  assign run_o     = (state == ST_COUNT);
  assign done_o    = run_o && rise_i && !en_wr_i && (edges == 3'(CAL_EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      edges <= '0;
      en_o  <= 1'b0;
    end else if (arm_evt) begin
      state <= wake_i ? ST_BRK_WAIT : ST_START;
      edges <= '0;
      en_o  <= 1'b1;
    end else if (abort_evt) begin
      state <= ST_IDLE;
      en_o  <= 1'b0;
    end else begin
      unique case (state)
        ST_BRK_WAIT: if (fall_i) state <= ST_BRK_LOW;
        ST_BRK_LOW:  if (rise_i) state <= ST_START;
        ST_START:    if (fall_i) state <= ST_EDGE1;
        ST_EDGE1: begin
          if (rise_i) begin
            state <= ST_COUNT;
            edges <= 3'd1;
          end
        end
        ST_COUNT: begin
          if (done_o) begin
            state <= ST_IDLE;
            en_o  <= 1'b0;
          end else if (rise_i) begin
            edges <= edges + 3'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (done_o) flag_o <= 1'b1;
    else if (rd_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
  parameter int CNT_W     = 16,
  parameter int BASE_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             wake_i,
  input  logic             fast_i,
  input  logic             wide_i,
  input  logic             rd_i,
  output logic [CNT_W-1:0] divisor_o,
  output logic             done_flag_o,
  output logic             en_o,
  output logic             rx_hold_o,
  output logic             ovf_o
);
  logic             rise_evt, fall_evt;
  logic             load_evt, run_lvl, done_evt, tick_evt, sat_evt;
  logic [CNT_W-1:0] cnt_val;

  ab_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .rise_o(rise_evt), .fall_o(fall_evt)
  );

  ab_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .wake_i(wake_i),
    .rise_i(rise_evt), .fall_i(fall_evt), .rd_i(rd_i),
    .en_o(en_o), .load_o(load_evt), .run_o(run_lvl),
    .done_o(done_evt), .flag_o(done_flag_o)
  );

  ab_prescale #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(load_evt), .run_i(run_lvl),
    .fast_i(fast_i), .wide_i(wide_i), .tick_o(tick_evt)
  );

  ab_satcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt), .inc_i(tick_evt),
    .cnt_o(cnt_val), .sat_hit_o(sat_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        divisor_o <= '0;
    else if (done_evt) divisor_o <= cnt_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       ovf_o <= 1'b0;
    else if (en_wr_i && en_wdata_i)   ovf_o <= 1'b0;
    else if (sat_evt)                 ovf_o <= 1'b1;
  end

  assign rx_hold_o = en_o;
endmodule

// File: rtl/autobaud_chk.sv
module autobaud_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_wr_i,
  input logic             en_wdata_i,
  input logic             rd_i,
  input logic             done_evt,
  input logic [CNT_W-1:0] divisor_o,
  input logic             done_flag_o,
  input logic             en_o,
  input logic             rx_hold_o,
  input logic             ovf_o
);
  p_div_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (divisor_o != '0));

  p_done_clears_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!en_o && done_flag_o));

  p_arm_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_i && en_wdata_i) |=> rx_hold_o);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !done_evt) |=> !done_flag_o);

  p_ovf_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(rx_hold_o));

  p_div_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done_evt) |-> $stable(divisor_o));
endmodule

bind autobaud_detect autobaud_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
  .rd_i(rd_i), .done_evt(done_evt), .divisor_o(divisor_o),
  .done_flag_o(done_flag_o), .en_o(en_o), .rx_hold_o(rx_hold_o), .ovf_o(ovf_o)
);

// File: tb/autobaud_detect_tb.sv
module autobaud_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int BASE = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, en_wr = 1'b0, en_wdata = 1'b0;
  logic wake = 1'b0, fast = 1'b0, wide = 1'b0, rd = 1'b0;
  logic [W-1:0] divisor;
  logic flag, en, hold, ovf;
  int   n_run = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_detect #(.CNT_W(W), .BASE_LOG2(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
    .wake_i(wake), .fast_i(fast), .wide_i(wide), .rd_i(rd),
    .divisor_o(divisor), .done_flag_o(flag), .en_o(en), .rx_hold_o(hold), .ovf_o(ovf)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int tick_period(input bit f, input bit w);
    if (f && w)      return 2 << (BASE - 1) << 0;
    else if (f || w) return 8 << (BASE - 1);
    else             return 32 << (BASE - 1);
  endfunction

  function automatic int expect_div(input int p, input bit f, input bit w);
    int v;
    v = 1 + (8 * p - 1) / tick_period(f, w);
    if (v > (1 << W) - 1) v = (1 << W) - 1;
    return v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_en(input bit v);
    @(negedge clk);
    en_wr = 1'b1; en_wdata = v;
    @(negedge clk);
    en_wr = 1'b0; en_wdata = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // start bit, 0x55 LSB first, stop bit, then idle
  task automatic send_bits(input int p, input int nbits);
    logic [9:0] frame;
    frame = {1'b1, 8'h55, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); rx = frame[i];
      cyc(p - 1);
    end
  endtask

  task automatic send_byte(input int p);
    send_bits(p, 10);
    rx = 1'b1;
    cyc(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int pl[6] = '{4, 5, 7, 9, 16, 31};
    int last;
    cyc(3);
    // R1 reset state
    chk(divisor, 0, "R1 divisor");
    chk(flag, 0, "R1 flag");
    chk(en, 0, "R1 enable");
    chk(hold, 0, "R1 hold");
    chk(ovf, 0, "R1 ovf");
    rst_n = 1'b1;
    cyc(2);

    // R2 R3 R4 R5: sweep selects and bit periods
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 6; k++) begin
        fast = s[0]; wide = s[1];
        write_en(1'b1);
        chk(hold, 1, "R5 hold while armed");
        send_byte(pl[k]);
        chk(divisor, expect_div(pl[k], fast, wide), "R2 R3 divisor");
        chk(en, 0, "R4 enable self-clear");
        chk(flag, 1, "R4 flag set");
        chk(hold, 0, "R5 hold released");
        chk(ovf, 0, "R7 no overflow");
        pulse_rd();
        chk(flag, 0, "R6 read clears flag");
      end
    end

    // R7 saturation: fastest tick, long bit period
    fast = 1'b1; wide = 1'b1;
    write_en(1'b1);
    send_byte(64);
    chk(divisor, (1 << W) - 1, "R7 saturated divisor");
    chk(ovf, 1, "R7 overflow set");
    pulse_rd();
    cyc(4);
    chk(ovf, 1, "R7 overflow sticky");
    write_en(1'b1);
    chk(ovf, 0, "R7 overflow cleared on arm");
    write_en(1'b0);

    // R9 wake: break then character
    wake = 1'b1;
    write_en(1'b1);
    @(negedge clk); rx = 1'b0;
    cyc(40);
    rx = 1'b1;
    cyc(20);
    send_byte(8);
    chk(divisor, expect_div(8, 1'b1, 1'b1), "R9 measured after break");
    chk(flag, 1, "R9 flag");
    pulse_rd();
    wake = 1'b0;

    // R8 abort
    last = expect_div(8, 1'b1, 1'b1);
    write_en(1'b1);
    send_bits(8, 4);
    write_en(1'b0);
    chk(en, 0, "R8 abort clears enable");
    chk(hold, 0, "R8 abort releases hold");
    chk(divisor, last, "R8 divisor kept on abort");
    send_bits(8, 10);
    rx = 1'b1;
    cyc(10);
    chk(divisor, last, "R8 divisor kept after line activity");
    chk(flag, 0, "R8 flag not set by abort");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule